// File: doc/BRIEF.md
# Indirect Register Access Port for a Network Controller

This block is the device side of a network controller's register interface. A host reaches it through a 16-bit I/O window with four word offsets. The host first loads a register index into a pointer register. It then reads or writes the selected register through one of two data ports: one for the control bank and one for the configuration bank. Reading a dedicated offset causes a soft reset, which returns every register in the block to its default value.

The control bank contains the main command/status word, the two halves of the initialization-block address, a read-only 32-bit identification pair and general-purpose storage words. When the host issues the init command, a counter with a parameterised latency runs. At the end of that latency the init-done flag is set. This counter stands in for the memory fetch of the initialization block, which the block does not perform. The start, stop and transmit-demand commands drive a small set of outputs toward the rest of the controller.

Top module: `nic_regport`

## Requirements
- R1: Word offsets are 0x10 for control data, 0x12 for the pointer, 0x14 for soft reset and 0x16 for configuration data. The pointer keeps the low PTR_W bits of a write and reads back zero-extended, so writing 88 returns 88. A read at edge k places its data on `io_rdata` after edge k, and `io_rdata` holds that value until the next read.
- R2: After `rst`, the pointer is 0 and control word 0 reads 0x0004. In control word 0, bit 0 is INIT, bit 1 is START, bit 2 is STOP, bit 3 is TX-DEMAND and bit 8 is INIT-DONE. Only STOP is set after reset.
- R3: A read of offset 0x14 returns 0 and returns the pointer and every register of both banks to their defaults, the same state as after `rst`.
- R4: Writing control word 0 with bit 0 set clears STOP and sets INIT. If the write is taken at edge k, INIT-DONE becomes set and INIT clears at edge k+INIT_LAT.
- R5: INIT-DONE clears only on a write of control word 0 with bit 8 set. A write with bit 8 clear leaves it set.
- R6: Writing bit 1 sets START, clears STOP and drives `run_active` high. Writing bit 2 sets STOP, clears START and INIT, and cancels a pending init. If bit 2 is written together with bit 0 or bit 1, bit 2 takes priority.
- R7: Writing bit 3 produces a one-cycle pulse on `tx_demand` in the cycle after the write. Bit 3 always reads as 0.
- R8: `init_block_addr` is {control word 2, control word 1}.
- R9: Control words 88 and 89 read {REV_NIB, PART_CODE, 12'h003} as low and high halves. With the defaults PART_CODE=0x2621 and REV_NIB=0, they read 0x1003 and 0x0262. Writes to these two words have no effect.
- R10: When the low byte of configuration word 20 equals 2, `wide_desc` is 1. `hold_full_pkt` follows bit 11 of configuration word 18.
- R11: Other control and configuration words store and return what is written. A pointer at or beyond the bank size reads 0 and discards writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Word offset within the I/O window |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Registered read data |
| init_block_addr | output | 32 | Initialization-block address |
| run_active | output | 1 | START state |
| tx_demand | output | 1 | One-cycle transmit-poll pulse |
| wide_desc | output | 1 | 32-bit descriptor style selected |
| hold_full_pkt | output | 1 | Buffer a whole frame before transmit |

## Verification
The bench builds the block with INIT_LAT=6 and keeps the default bank sizes of 128 control words and 32 configuration words. This lets it read control word 0 on every cycle across the whole init window and observe the exact edge at which INIT-DONE appears. With 128 control words, pointer 200 falls outside the control bank, and pointer 40 falls outside the configuration bank, so both out-of-range paths are exercised.

// File: rtl/nic_regport_pkg.sv
package nic_regport_pkg;
  // word offsets inside the I/O window
  localparam logic [7:0] OFF_CDATA = 8'h10;
  localparam logic [7:0] OFF_PTR   = 8'h12;
  localparam logic [7:0] OFF_SRST  = 8'h14;
  localparam logic [7:0] OFF_BDATA = 8'h16;

  // control word 0 bit positions
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_IDON = 8;

  // fixed register indices
  localparam int IDX_CTRL   = 0;
  localparam int IDX_IBA_LO = 1;
  localparam int IDX_IBA_HI = 2;
  localparam int IDX_ID_LO  = 88;
  localparam int IDX_ID_HI  = 89;
  localparam int IDX_HOLD   = 18;
  localparam int IDX_WIDE   = 20;
  localparam int HOLD_BIT   = 11;
  localparam logic [7:0] WIDE_CODE = 8'd2;

  typedef enum logic [2:0] {
    PORT_NONE, PORT_CDATA, PORT_PTR, PORT_SRST, PORT_BDATA
  } port_e;

  typedef struct packed {
    logic idon;
    logic tdmd;
    logic stop;
    logic strt;
    logic init;
  } cmd_t;
endpackage

// File: rtl/regport_decode.sv
module regport_decode
  import nic_regport_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output port_e             sel
);
  always_comb begin
    if (addr == ADDR_W'(OFF_CDATA))      sel = PORT_CDATA;
    else if (addr == ADDR_W'(OFF_PTR))   sel = PORT_PTR;
    else if (addr == ADDR_W'(OFF_SRST))  sel = PORT_SRST;
    else if (addr == ADDR_W'(OFF_BDATA)) sel = PORT_BDATA;
    else                                 sel = PORT_NONE;
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int N     = 32,
  parameter int IDX_W = 8,
  parameter int DW    = 16,
  parameter int TAP_A = 0,
  parameter int TAP_B = 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    tap_a,
  output logic [DW-1:0]    tap_b
);
  logic [N-1:0][DW-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (clr)
        q[i] <= '0;
      else if (we && (widx == IDX_W'(i)))
        q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (ridx == IDX_W'(i)) rdata = q[i];
  end

  assign tap_a = q[TAP_A];
  assign tap_b = q[TAP_B];
endmodule

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import nic_regport_pkg::*;
#(
  parameter int INIT_LAT = 16
) (
  input  logic        clk,
  input  logic        clr,
  input  logic        we,
  input  cmd_t        cmd,
  output logic        init_q,
  output logic        strt_q,
  output logic        stop_q,
  output logic        idon_q,
  output logic        tdmd_pulse,
  output logic [15:0] word
);
  localparam int CNT_W = $clog2(INIT_LAT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      init_q     <= 1'b0;
      strt_q     <= 1'b0;
      stop_q     <= 1'b1;
      idon_q     <= 1'b0;
      tdmd_pulse <= 1'b0;
      cnt        <= '0;
    end else begin
      tdmd_pulse <= 1'b0;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          idon_q <= 1'b1;
          init_q <= 1'b0;
        end
      end
      if (we) begin
        if (cmd.stop) begin
          stop_q <= 1'b1;
          strt_q <= 1'b0;
          init_q <= 1'b0;
          cnt    <= '0;
        end else begin
          if (cmd.init) begin
            init_q <= 1'b1;
            stop_q <= 1'b0;
            cnt    <= CNT_W'(INIT_LAT);
          end
          if (cmd.strt) begin
            strt_q <= 1'b1;
            stop_q <= 1'b0;
          end
        end
        if (cmd.tdmd) tdmd_pulse <= 1'b1;
        if (cmd.idon) idon_q <= 1'b0;
      end
    end
  end

  always_comb begin
    word         = '0;
    word[B_INIT] = init_q;
    word[B_STRT] = strt_q;
    word[B_STOP] = stop_q;
    word[B_IDON] = idon_q;
  end
endmodule

// File: rtl/nic_regport.sv
module nic_regport
  import nic_regport_pkg::*;
#(
  parameter int          ADDR_W    = 5,
  parameter int          PTR_W     = 8,
  parameter int          CSR_N     = 128,
  parameter int          BCR_N     = 32,
  parameter int          INIT_LAT  = 16,
  parameter logic [15:0] PART_CODE = 16'h2621,
  parameter logic [3:0]  REV_NIB   = 4'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [15:0]       io_wdata,
  output logic [15:0]       io_rdata,
  output logic [31:0]       init_block_addr,
  output logic              run_active,
  output logic              tx_demand,
  output logic              wide_desc,
  output logic              hold_full_pkt
);
  localparam logic [31:0] ID_WORD = {REV_NIB, PART_CODE, 12'h003};

  port_e             sel;
  logic [PTR_W-1:0]  ptr_q;
  logic              srst;
  logic              clr;
  logic              ctrl_we;
  logic              csr_we;
  logic              bcr_we;
  logic [15:0]       ctrl_word;
  logic [15:0]       csr_bank_rd;
  logic [15:0]       bcr_bank_rd;
  logic [15:0]       csr_rd;
  logic [15:0]       iba_lo;
  logic [15:0]       iba_hi;
  logic [15:0]       bcr_hold;
  logic [15:0]       bcr_wide;
  logic              init_q;
  logic              strt_q;
  logic              stop_q;
  logic              idon_q;
  cmd_t              cmd;

  regport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (io_addr),
    .sel  (sel)
  );

  assign srst = io_rd && (sel == PORT_SRST);
  assign clr  = rst || srst;

  always_ff @(posedge clk) begin
    if (clr)
      ptr_q <= '0;
    else if (io_wr && sel == PORT_PTR)
      ptr_q <= io_wdata[PTR_W-1:0];
  end

  // control word 0 and the identification pair are not bank storage
  assign ctrl_we = io_wr && (sel == PORT_CDATA) && (ptr_q == PTR_W'(IDX_CTRL));
  assign csr_we  = io_wr && (sel == PORT_CDATA) && (ptr_q != PTR_W'(IDX_CTRL))
                   && (ptr_q != PTR_W'(IDX_ID_LO)) && (ptr_q != PTR_W'(IDX_ID_HI));
  assign bcr_we  = io_wr && (sel == PORT_BDATA);

  always_comb begin
    cmd.init = io_wdata[B_INIT];
    cmd.strt = io_wdata[B_STRT];
    cmd.stop = io_wdata[B_STOP];
    cmd.tdmd = io_wdata[B_TDMD];
    cmd.idon = io_wdata[B_IDON];
  end

  csr_ctrl #(.INIT_LAT(INIT_LAT)) u_ctrl (
    .clk        (clk),
    .clr        (clr),
    .we         (ctrl_we),
    .cmd        (cmd),
    .init_q     (init_q),
    .strt_q     (strt_q),
    .stop_q     (stop_q),
    .idon_q     (idon_q),
    .tdmd_pulse (tx_demand),
    .word       (ctrl_word)
  );

  reg_bank #(
    .N(CSR_N), .IDX_W(PTR_W), .DW(16), .TAP_A(IDX_IBA_LO), .TAP_B(IDX_IBA_HI)
  ) u_csr (
    .clk   (clk),
    .clr   (clr),
    .we    (csr_we),
    .widx  (ptr_q),
    .wdata (io_wdata),
    .ridx  (ptr_q),
    .rdata (csr_bank_rd),
    .tap_a (iba_lo),
    .tap_b (iba_hi)
  );

  reg_bank #(
    .N(BCR_N), .IDX_W(PTR_W), .DW(16), .TAP_A(IDX_HOLD), .TAP_B(IDX_WIDE)
  ) u_bcr (
    .clk   (clk),
    .clr   (clr),
    .we    (bcr_we),
    .widx  (ptr_q),
    .wdata (io_wdata),
    .ridx  (ptr_q),
    .rdata (bcr_bank_rd),
    .tap_a (bcr_hold),
    .tap_b (bcr_wide)
  );

  always_comb begin
    if (ptr_q == PTR_W'(IDX_CTRL))       csr_rd = ctrl_word;
    else if (ptr_q == PTR_W'(IDX_ID_LO)) csr_rd = ID_WORD[15:0];
    else if (ptr_q == PTR_W'(IDX_ID_HI)) csr_rd = ID_WORD[31:16];
    else                                 csr_rd = csr_bank_rd;
  end

  always_ff @(posedge clk) begin
    if (rst)
      io_rdata <= '0;
    else if (io_rd) begin
      case (sel)
        PORT_CDATA: io_rdata <= csr_rd;
        PORT_PTR:   io_rdata <= {{(16-PTR_W){1'b0}}, ptr_q};
        PORT_BDATA: io_rdata <= bcr_bank_rd;
        default:    io_rdata <= '0;
      endcase
    end
  end

  assign init_block_addr = {iba_hi, iba_lo};
  assign run_active      = strt_q;
  assign wide_desc       = (bcr_wide[7:0] == WIDE_CODE);
  assign hold_full_pkt   = bcr_hold[HOLD_BIT];
endmodule

// File: rtl/nic_regport_chk.sv
module nic_regport_chk #(
  parameter int ADDR_W = 5,
  parameter int PTR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              io_rd,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [15:0]       io_wdata,
  input logic              tx_demand,
  input logic [PTR_W-1:0]  ptr_q,
  input logic              stop_q,
  input logic              strt_q,
  input logic              init_q,
  input logic              idon_q
);
  logic ctrl_wr;
  logic ptr_wr;
  logic srst_rd;
  assign ctrl_wr = io_wr && (io_addr == ADDR_W'(8'h10)) && (ptr_q == '0);
  assign ptr_wr  = io_wr && (io_addr == ADDR_W'(8'h12));
  assign srst_rd = io_rd && (io_addr == ADDR_W'(8'h14));

  assert_rw_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && io_wr));

  assert_ptr_load_R1: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> (ptr_q == $past(io_wdata[PTR_W-1:0])));

  assert_srst_default_R3: assert property (@(posedge clk) disable iff (rst)
    srst_rd |=> (stop_q && !strt_q && !init_q && !idon_q && ptr_q == '0));

  assert_idon_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(idon_q) |-> $past(init_q));

  assert_idon_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (idon_q && !(ctrl_wr && io_wdata[8]) && !srst_rd) |=> idon_q);

  assert_stop_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(stop_q && (strt_q || init_q)));

  assert_tdmd_cause_R7: assert property (@(posedge clk) disable iff (rst)
    tx_demand |-> $past(ctrl_wr && io_wdata[3]));
endmodule

bind nic_regport nic_regport_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .tx_demand (tx_demand),
  .ptr_q     (ptr_q),
  .stop_q    (stop_q),
  .strt_q    (strt_q),
  .init_q    (init_q),
  .idon_q    (idon_q)
);

// File: tb/sim_nic_regport.sv
module sim_nic_regport;
  localparam int LAT = 6;
  localparam logic [4:0] A_CD = 5'h10, A_PT = 5'h12, A_SR = 5'h14, A_BD = 5'h16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic [31:0] init_block_addr;
  logic        run_active, tx_demand, wide_desc, hold_full_pkt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nic_regport #(.INIT_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .init_block_addr(init_block_addr),
    .run_active(run_active), .tx_demand(tx_demand), .wide_desc(wide_desc),
    .hold_full_pkt(hold_full_pkt)
  );

  // ---------------- behavioural reference ----------------
  int csr_m[128];
  int bcr_m[32];
  int ptr_m, cnt_m;
  bit init_m, strt_m, stop_m, idon_m, tdmd_m;
  logic [15:0] rdata_m;

  task automatic model_defaults();
    foreach (csr_m[i]) csr_m[i] = 0;
    foreach (bcr_m[i]) bcr_m[i] = 0;
    ptr_m = 0; cnt_m = 0;
    init_m = 0; strt_m = 0; stop_m = 1; idon_m = 0; tdmd_m = 0;
  endtask

  function automatic logic [15:0] csr_view(int idx);
    if (idx == 0)  return {7'd0, idon_m, 5'd0, stop_m, strt_m, init_m};
    if (idx == 88) return 16'h1003;
    if (idx == 89) return 16'h0262;
    if (idx < 128) return 16'(csr_m[idx]);
    return 16'h0;
  endfunction

  always @(posedge clk) begin
    logic [15:0] rv;
    if (rst) begin
      model_defaults();
      rdata_m = 16'h0;
    end else begin
      rv = rdata_m;
      if (io_rd) begin
        if (io_addr == A_CD)      rv = csr_view(ptr_m);
        else if (io_addr == A_PT) rv = 16'(ptr_m);
        else if (io_addr == A_BD) rv = (ptr_m < 32) ? 16'(bcr_m[ptr_m]) : 16'h0;
        else                      rv = 16'h0;
      end
      tdmd_m = 0;
      if (cnt_m > 0) begin
        if (cnt_m == 1) begin idon_m = 1; init_m = 0; end
        cnt_m--;
      end
      if (io_wr) begin
        if (io_addr == A_PT) ptr_m = int'(io_wdata[7:0]);
        else if (io_addr == A_BD && ptr_m < 32) bcr_m[ptr_m] = int'(io_wdata);
        else if (io_addr == A_CD && ptr_m == 0) begin
          if (io_wdata[2]) begin stop_m = 1; strt_m = 0; init_m = 0; cnt_m = 0; end
          else begin
            if (io_wdata[0]) begin init_m = 1; stop_m = 0; cnt_m = LAT; end
            if (io_wdata[1]) begin strt_m = 1; stop_m = 0; end
          end
          if (io_wdata[3]) tdmd_m = 1;
          if (io_wdata[8]) idon_m = 0;
        end else if (io_addr == A_CD && ptr_m != 88 && ptr_m != 89 && ptr_m < 128)
          csr_m[ptr_m] = int'(io_wdata);
      end
      if (io_rd && io_addr == A_SR) model_defaults();
      rdata_m = rv;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1 rdata", {16'h0, io_rdata}, {16'h0, rdata_m});
      check("R7 tx_demand", {31'h0, tx_demand}, {31'h0, tdmd_m});
      check("R6 run_active", {31'h0, run_active}, {31'h0, strt_m});
      check("R8 init_block_addr", init_block_addr, {16'(csr_m[2]), 16'(csr_m[1])});
      check("R10 wide_desc", {31'h0, wide_desc}, {31'h0, (bcr_m[20] & 255) == 2});
      check("R10 hold_full_pkt", {31'h0, hold_full_pkt}, {31'h0, bcr_m[18][11]});
    end
  end

  // tasks start and end just after a falling edge
  task automatic do_wr(logic [4:0] a, logic [15:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_rd(logic [4:0] a, output logic [15:0] v);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    do_rd(A_CD, v);  check("R2 ctrl after reset", {16'h0, v}, 32'h0004);
    do_rd(A_PT, v);  check("R2 pointer after reset", {16'h0, v}, 32'h0);

    // R1 pointer readback, R9 identification
    do_wr(A_PT, 16'd88); do_rd(A_PT, v); check("R1 pointer readback", {16'h0, v}, 32'd88);
    do_rd(A_CD, v); check("R9 id low", {16'h0, v}, 32'h1003);
    do_wr(A_PT, 16'd89); do_rd(A_CD, v); check("R9 id high", {16'h0, v}, 32'h0262);
    do_wr(A_CD, 16'hFFFF); do_rd(A_CD, v); check("R9 id write ignored", {16'h0, v}, 32'h0262);

    // R8 init block address
    do_wr(A_PT, 16'd1); do_wr(A_CD, 16'h1234);
    do_wr(A_PT, 16'd2); do_wr(A_CD, 16'hABCD);
    check("R8 address halves", init_block_addr, 32'hABCD1234);

    // R4 init with exact latency
    do_wr(A_PT, 16'd0);
    do_wr(A_CD, 16'h0001);
    for (int i = 1; i <= LAT; i++) begin
      do_rd(A_CD, v); check("R4 init pending", {16'h0, v}, 32'h0001);
    end
    do_rd(A_CD, v); check("R4 init done", {16'h0, v}, 32'h0100);

    // R5 write-one-to-clear
    do_wr(A_CD, 16'h0000); do_rd(A_CD, v); check("R5 idon kept", {16'h0, v}, 32'h0100);
    do_wr(A_CD, 16'h0100); do_rd(A_CD, v); check("R5 idon cleared", {16'h0, v}, 32'h0000);

    // R6 start, R7 transmit demand
    do_wr(A_CD, 16'h0002); do_rd(A_CD, v); check("R6 started", {16'h0, v}, 32'h0002);
    check("R6 run_active", {31'h0, run_active}, 32'h1);
    do_wr(A_CD, 16'h0008);
    check("R7 pulse high", {31'h0, tx_demand}, 32'h1);
    do_rd(A_CD, v);
    check("R7 pulse ends", {31'h0, tx_demand}, 32'h0);
    check("R7 bit reads zero", {16'h0, v}, 32'h0002);

    // R6 stop, priority, cancellation
    do_wr(A_CD, 16'h0004); do_rd(A_CD, v); check("R6 stopped", {16'h0, v}, 32'h0004);
    do_wr(A_CD, 16'h0007); do_rd(A_CD, v); check("R6 stop priority", {16'h0, v}, 32'h0004);
    do_wr(A_CD, 16'h0001); do_wr(A_CD, 16'h0004);
    repeat (LAT + 2) @(negedge clk);
    do_rd(A_CD, v); check("R6 init cancelled", {16'h0, v}, 32'h0004);

    // R10 configuration bank
    do_wr(A_PT, 16'd20); do_wr(A_BD, 16'h0002);
    check("R10 wide select", {31'h0, wide_desc}, 32'h1);
    do_rd(A_BD, v); check("R10 cfg readback", {16'h0, v}, 32'h0002);
    do_wr(A_PT, 16'd18); do_wr(A_BD, 16'h0800);
    check("R10 hold select", {31'h0, hold_full_pkt}, 32'h1);

    // R11 storage and range
    do_wr(A_PT, 16'd15); do_wr(A_CD, 16'hBEEF); do_rd(A_CD, v);
    check("R11 storage", {16'h0, v}, 32'hBEEF);
    do_wr(A_PT, 16'd200); do_wr(A_CD, 16'h5555); do_rd(A_CD, v);
    check("R11 ctrl out of range", {16'h0, v}, 32'h0);
    do_wr(A_PT, 16'd40); do_wr(A_BD, 16'h5555); do_rd(A_BD, v);
    check("R11 cfg out of range", {16'h0, v}, 32'h0);

    // R3 soft reset
    do_wr(A_PT, 16'd0); do_wr(A_CD, 16'h0002);
    do_rd(A_SR, v); check("R3 reset port reads 0", {16'h0, v}, 32'h0);
    do_rd(A_PT, v); check("R3 pointer cleared", {16'h0, v}, 32'h0);
    do_rd(A_CD, v); check("R3 ctrl default", {16'h0, v}, 32'h0004);
    check("R3 address cleared", init_block_addr, 32'h0);
    check("R3 cfg cleared", {30'h0, wide_desc, hold_full_pkt}, 32'h0);
    do_wr(A_PT, 16'd15); do_rd(A_CD, v); check("R3 storage cleared", {16'h0, v}, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule